// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block keeps one SDRAM rank refreshed on a fixed cadence. A free-running interval counter produces a refresh tick every `cfg_interval` cycles and adds it to a small backlog counter. While the backlog is non-zero and no sequence is running, the block raises a refresh request towards the normal access scheduler. The scheduler answers with a grant when the rank suits it. From the cycle after the grant, the block reports busy and owns the command bus. It closes every open bank with a precharge-all, but only when the bank-status input shows that some bank is open. It then waits out the precharge time and issues the refresh command. The refresh carries no address, because the device steps its own row counter. The block holds busy until the refresh cycle time has passed, so the scheduler can issue neither an activate nor another refresh during that time.

The timing inputs are counts of clock cycles. They are sampled when a sequence starts, and they must stay stable while busy is high. If the scheduler postpones refresh, the backlog grows up to a fixed depth. At that depth an urgent flag tells the scheduler to stop deferring.

Top module: `sdram_refresh_seq`

## Requirements
- R1: The interval counter counts every clock cycle and never stops, including during a refresh sequence. It produces a tick in the cycle where its count reaches `cfg_interval`-1, and restarts from zero in the next cycle. Each tick adds one to the backlog, and `ref_req` is high in any cycle where the backlog is non-zero and `ref_busy` is low.
- R2: Once raised, `ref_req` stays high until it is granted. A `ref_grant` that arrives while `ref_req` is low is ignored: `ref_busy` stays low in the next cycle.
- R3: When `ref_grant` and `ref_req` are both high in cycle g, `ref_busy` is high from cycle g+1 and `ref_req` is low for the whole sequence.
- R4: A precharge-all is issued in cycle g+1 only if `banks_idle` was low in the grant cycle g. If `banks_idle` was high, no precharge-all is issued.
- R5: The refresh command is issued max(`cfg_trp`,2) cycles after the precharge-all cycle. When the precharge-all was skipped, it is issued max(`cfg_trp`,2) cycles after the grant cycle.
- R6: If the refresh is issued in cycle r, `ref_busy` stays high through cycle r+max(`cfg_trfc`,2)-1 and is low in cycle r+max(`cfg_trfc`,2). No command is issued in between.
- R7: The backlog saturates at PEND_MAX (default 8), and ticks arriving at that level are dropped. `ref_urgent` is high exactly when the backlog equals PEND_MAX.
- R8: Command encoding: `cmd_valid` is high for exactly one cycle per command. `cmd_op` is 2'b01 for precharge-all and 2'b10 for refresh, and it is 2'b00 whenever `cmd_valid` is low.
- R9: During and directly after reset, `ref_req`, `ref_urgent`, `ref_busy` and `cmd_valid` are low and `cmd_op` is 2'b00.
- R10: Each issued refresh removes one entry from the backlog. A tick and an issued refresh in the same cycle leave the backlog unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interval | input | CNT_W | Refresh period in cycles (at least 2) |
| cfg_trp | input | TW | Precharge time in cycles |
| cfg_trfc | input | TW | Refresh cycle time in cycles |
| ref_grant | input | 1 | Scheduler grants the pending request |
| banks_idle | input | 1 | High when every bank is closed |
| ref_req | output | 1 | Refresh wanted |
| ref_urgent | output | 1 | Backlog at its maximum |
| ref_busy | output | 1 | Sequence running; scheduler must stay silent |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 2 | Command opcode (01 precharge-all, 10 refresh) |

## Verification
The bench targets several corner cases:
- Grants that arrive before any request: a design that accepts them would start a refresh that nothing asked for.
- Grants made while all banks are already closed: a design that fails to skip the close would waste cycles and shift the refresh.
- Timing values of 0 and 1, which must clamp to a two-cycle spacing: a design without the clamp would wrap its down-counter and hang busy for hundreds of cycles.
- A long run without grants, which must saturate the backlog, raise urgent and then drain.
- A period shorter than the refresh cycle time, so that ticks land during a sequence and on the refresh cycle itself: a design that lets one update win over the other in that cycle ends up with a backlog that is off by one.

// File: rtl/sdram_ref_pkg.sv
// Shared types for the refresh sequencer: sequence states and command opcodes.
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREA     = 3'd1,
        ST_WAIT_RP  = 3'd2,
        ST_REF      = 3'd3,
        ST_WAIT_RFC = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PREA = 2'b01,
        OP_REF  = 2'b10
    } dram_op_t;

endpackage

// File: rtl/ref_interval_timer.sv
// Free-running period counter. Raises tick for one cycle when the count reaches
// cfg_interval-1, then restarts at zero. Assumes cfg_interval >= 2; a lowered
// interval takes effect at once because the compare uses >=.
module ref_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_interval,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    // Period end detection.
    assign tick = (cnt >= (cfg_interval - CNT_W'(1)));

    // Count cycles, wrap at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ref_pending_ctr.sv
// Backlog of refresh ticks not yet serviced. Saturates at DEPTH (further ticks
// are dropped); a tick and a service in the same cycle cancel out.
module ref_pending_ctr #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic serviced,
    output logic pend_nz,
    output logic full
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] MAXV = PW'(DEPTH);

    logic [PW-1:0] cnt;

    // Status decodes.
    assign pend_nz = (cnt != '0);
    assign full    = (cnt == MAXV);

    // Saturating up/down count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({tick, serviced})
                2'b10:   if (cnt != MAXV) cnt <= cnt + PW'(1);
                2'b01:   if (cnt != '0)   cnt <= cnt - PW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ref_seq_fsm.sv
// Refresh command sequence: on grant, optionally precharge-all (only if a bank is
// open), wait max(trp,2) cycles, issue refresh, then lock out for max(trfc,2)
// cycles. Assumes cfg_trp/cfg_trfc stable while busy.
module ref_seq_fsm
    import sdram_ref_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_pending,
    input  logic          grant,
    input  logic          banks_idle,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trfc,
    output logic          busy,
    output logic          cmd_valid,
    output dram_op_t      cmd_op,
    output logic          ref_issue
);
    seq_state_t    state, state_n;
    logic [TW-1:0] tmr;
    logic          tmr_done;

    // Saturating decrement used for timer loads.
    function automatic logic [TW-1:0] less_one(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    assign tmr_done = (tmr <= TW'(1));

    // Next-state selection.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (req_pending && grant)
                             state_n = banks_idle ? ST_WAIT_RP : ST_PREA;
            ST_PREA:     state_n = ST_WAIT_RP;
            ST_WAIT_RP:  if (tmr_done) state_n = ST_REF;
            ST_REF:      state_n = ST_WAIT_RFC;
            ST_WAIT_RFC: if (tmr_done) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Wait timer: loaded at each anchor point, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (state == ST_PREA || (state == ST_IDLE && state_n == ST_WAIT_RP))
            tmr <= less_one(cfg_trp);
        else if (state == ST_REF)
            tmr <= less_one(cfg_trfc);
        else if (tmr != '0)
            tmr <= tmr - TW'(1);
    end

    // Output decodes.
    always_comb begin
        busy      = (state != ST_IDLE);
        ref_issue = (state == ST_REF);
        cmd_valid = (state == ST_PREA) || (state == ST_REF);
        cmd_op    = (state == ST_PREA) ? OP_PREA :
                    (state == ST_REF)  ? OP_REF  : OP_NONE;
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
// Top of the refresh sequencer: period timer, backlog counter and command FSM.
// Assumes the scheduler issues nothing while ref_busy is high.
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TW       = 8,
    parameter int PEND_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trfc,
    input  logic             ref_grant,
    input  logic             banks_idle,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ref_busy,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op
);
    logic     tick, pend_nz, ref_issue;
    dram_op_t op_w;

    ref_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .tick(tick)
    );

    ref_pending_ctr #(.DEPTH(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick(tick), .serviced(ref_issue),
        .pend_nz(pend_nz), .full(ref_urgent)
    );

    ref_seq_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_pending(pend_nz), .grant(ref_grant),
        .banks_idle(banks_idle), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
        .busy(ref_busy), .cmd_valid(cmd_valid), .cmd_op(op_w),
        .ref_issue(ref_issue)
    );

    // Request only while no sequence runs.
    assign ref_req = pend_nz && !ref_busy;
    assign cmd_op  = op_w;
endmodule

// File: rtl/sdram_refresh_chk.sv
// Protocol checker for sdram_refresh_seq, attached by bind. Tracks cycles since
// the last wait anchor and since the last refresh with small saturating counters.
module sdram_refresh_chk
    import sdram_ref_pkg::*;
#(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] cfg_trp,
    input logic [TW-1:0] cfg_trfc,
    input logic          ref_grant,
    input logic          banks_idle,
    input logic          ref_req,
    input logic          ref_urgent,
    input logic          ref_busy,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op
);
    logic [TW:0] since_anchor, since_ref;
    logic        ref_seen;
    logic        is_prea, is_ref;

    assign is_prea = cmd_valid && (cmd_op == OP_PREA);
    assign is_ref  = cmd_valid && (cmd_op == OP_REF);

    // Cycles since grant or precharge-all.
    always_ff @(posedge clk) begin
        if (!rst_n)                              since_anchor <= '0;
        else if ((ref_req && ref_grant) || is_prea) since_anchor <= (TW+1)'(1);
        else if (since_anchor != '1)             since_anchor <= since_anchor + (TW+1)'(1);
    end

    // Cycles since the last refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= '0;
            ref_seen  <= 1'b0;
        end else if (is_ref) begin
            since_ref <= (TW+1)'(1);
            ref_seen  <= 1'b1;
        end else if (since_ref != '1) begin
            since_ref <= since_ref + (TW+1)'(1);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_grant |=> ref_req); // R2
    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_grant |=> ref_busy); // R3
    AST_PREA_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |-> $past(!banks_idle)); // R4
    AST_TRP_BEFORE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> since_anchor >= {1'b0, cfg_trp}); // R5
    AST_TRFC_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_seen && (since_ref < {1'b0, cfg_trfc}) |-> ref_busy && !cmd_valid); // R6
    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent && !ref_busy |-> ref_req); // R7
    AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid ? ($countones(cmd_op) == 1) : (cmd_op == 2'b00)); // R8
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R8
endmodule

bind sdram_refresh_seq sdram_refresh_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
    .ref_grant(ref_grant), .banks_idle(banks_idle), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_busy(ref_busy), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op)
);

// File: tb/tb_sdram_refresh_seq.sv
`timescale 1ns/1ps
// Bench: behavioural event-time model compared against the ports every cycle.
module tb_sdram_refresh_seq;
    localparam int CNT_W = 16;
    localparam int TW    = 8;
    localparam int PMAX  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_interval;
    logic [TW-1:0]    cfg_trp, cfg_trfc;
    logic             ref_grant = 1'b0, banks_idle = 1'b1;
    logic             ref_req, ref_urgent, ref_busy, cmd_valid;
    logic [1:0]       cmd_op;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    // Model state.
    int  cyc = 0, m_icnt = 0, m_pend = 0;
    int  pre_at = -1, ref_at = -1, end_at = -1;
    bit  m_active = 1'b0;

    always #2 clk = ~clk;

    sdram_refresh_seq #(.CNT_W(CNT_W), .TW(TW), .PEND_MAX(PMAX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_trp(cfg_trp),
        .cfg_trfc(cfg_trfc), .ref_grant(ref_grant), .banks_idle(banks_idle),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int clamp2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    // One cycle: mode 0 no grant, 1 grant when requested, 2 grant always.
    task automatic step(input int mode, input bit idle);
        bit e_req, e_cv, tick, iss;
        int e_op;
        e_req = !m_active && (m_pend > 0);
        e_cv  = (cyc == pre_at) || (cyc == ref_at);
        e_op  = (cyc == pre_at) ? 1 : ((cyc == ref_at) ? 2 : 0);
        ref_grant  = (mode == 2) || (mode == 1 && e_req);
        banks_idle = idle;
        #1;
        check("R1/R2 ref_req", int'(ref_req), int'(e_req));
        check("R3/R6 ref_busy", int'(ref_busy), int'(m_active));
        check("R4/R5/R8 cmd_valid", int'(cmd_valid), int'(e_cv));
        check("R4/R5/R8 cmd_op", int'(cmd_op), e_op);
        check("R7/R10 ref_urgent", int'(ref_urgent), int'(m_pend == PMAX));
        // Model update for the coming edge.
        tick = (m_icnt >= int'(cfg_interval) - 1);
        m_icnt = tick ? 0 : m_icnt + 1;
        iss = (cyc == ref_at);
        if (tick && !iss && m_pend < PMAX) m_pend++;
        else if (!tick && iss && m_pend > 0) m_pend--;
        if (m_active && cyc + 1 >= end_at) m_active = 1'b0;
        if (ref_grant && e_req) begin
            pre_at   = idle ? -1 : cyc + 1;
            ref_at   = (idle ? cyc : cyc + 1) + clamp2(int'(cfg_trp));
            end_at   = ref_at + clamp2(int'(cfg_trfc));
            m_active = 1'b1;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n, input int mode, input int idle_pat);
        for (int i = 0; i < n; i++)
            step(mode, (idle_pat == 2) ? bit'((i / 3) % 2) : bit'(idle_pat));
    endtask

    // Wait (without grants) until no sequence is active, then change timing.
    task automatic settle();
        while (m_active) step(0, 1'b1);
    endtask

    initial begin
        cfg_interval = 16'd20;
        cfg_trp  = 8'd3;
        cfg_trfc = 8'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 ref_req", int'(ref_req), 0);
        check("R9 ref_busy", int'(ref_busy), 0);
        check("R9 ref_urgent", int'(ref_urgent), 0);
        check("R9 cmd_valid", int'(cmd_valid), 0);
        check("R9 cmd_op", int'(cmd_op), 0);
        rst_n = 1'b1;
        // R2: grants before the first request are ignored; then idle-bank skip (R4)
        run(60, 2, 1);
        // R4/R5: open banks force a precharge-all
        run(60, 1, 0);
        // R5/R6: tiny timing values clamp to two cycles
        settle(); cfg_trp = 8'd1; cfg_trfc = 8'd0;
        run(80, 1, 2);
        // R7: starve the request, backlog saturates, then drain
        settle(); cfg_trp = 8'd4; cfg_trfc = 8'd9;
        run(200, 0, 0);
        run(200, 1, 2);
        // R10 / R1: period shorter than the sequence, ticks land on refresh cycles
        settle(); cfg_interval = 16'd7;
        run(150, 1, 0);
        run(60, 0, 1);
        run(120, 1, 1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule